// File: doc/BRIEF.md
# ISA Extension Register Write Filter

This block holds the register that reports which instruction-set extensions are switched on. Each extension letter has one bit. The block filters every software write so that only a self-consistent set of extensions is ever stored. Any write that would leave the core without a base integer set is discarded. A write that asks for the reduced embedded base is also discarded. Letters the hardware cannot provide, and letters the block does not handle, are stripped out. Double precision is removed when single precision is absent. Compressed instructions are refused while the next fetch address is not word aligned.

The two top bits of the register hold a native-width code that software cannot change. A one-cycle pulse tells the rest of the core that the stored configuration has changed, so that it can discard anything it derived from the old one.

Top module: `isa_ext_filter`

## Requirements
- R1: After reset, the register reads as the hardware support mask in bits [25:0], the native width code (default 1) in bits [31:30], and zero in bits [29:26]; the change pulse is low.
- R2: While writeAllow is low, a write leaves the register unchanged and raises no pulse.
- R3: A write whose data has neither bit 8 (I) nor bit 4 (E) set is dropped entirely.
- R4: A write whose data has bit 4 (E) set is dropped entirely, even when bit 8 (I) is also set.
- R5: An accepted write stores data AND supportMask AND the handled-letter set. The handled letters are A=0, C=2, D=3, E=4, F=5, I=8, M=12, S=18 and U=20. Every other letter bit reads zero.
- R6: If bit 3 (D) survives the masking while bit 5 (F) does not, bit 3 is stored as zero.
- R7: If bit 2 (C) survives the masking while nextPcLow is not 0, bit 2 is stored as zero; with nextPcLow equal to 0, C is kept.
- R8: Bits [31:30] keep their value across every write, whatever the data holds there, and bits [29:26] stay zero.
- R9: changePulse is high for exactly the one cycle after a clock edge that stored a value different from the previous one. It stays low for dropped writes and for writes of an identical value.
- R10: An accepted write sampled at a rising edge is visible on extReg immediately after that edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| supportMask | input | 26 | Letters the hardware can provide |
| writeAllow | input | 1 | Enables writes to the register |
| nextPcLow | input | 2 | Low bits of the next instruction address |
| extReg | output | 32 | Stored register value |
| changePulse | output | 1 | One-cycle pulse when the stored value changed |

## Verification
A write presented with wrEn at a rising edge shows up on extReg after that edge. The pulse for the same write is registered at the same edge, so both results are due one cycle after the stimulus. The bench drives inputs on falling edges and samples both outputs on the next falling edge. It also samples extReg once just before that edge, to confirm that the value has not moved early. Its model applies the drop, mask, D and C rules in the bench and keeps a shadow of the expected register, so the pulse is predicted by comparing the shadow before and after each write.

// File: rtl/isa_ext_pkg.sv
package isa_ext_pkg;
  localparam int XLEN        = 32;
  localparam int LETTERS     = 26;
  localparam int WCODE_W     = 2;
  localparam int PAD_W       = XLEN - WCODE_W - LETTERS;

  localparam int BIT_A = 0;
  localparam int BIT_C = 2;
  localparam int BIT_D = 3;
  localparam int BIT_E = 4;
  localparam int BIT_F = 5;
  localparam int BIT_I = 8;
  localparam int BIT_M = 12;
  localparam int BIT_S = 18;
  localparam int BIT_U = 20;

  function automatic logic [LETTERS-1:0] handledSet();
    logic [LETTERS-1:0] m;
    m = '0;
    m[BIT_A] = 1'b1; m[BIT_C] = 1'b1; m[BIT_D] = 1'b1;
    m[BIT_E] = 1'b1; m[BIT_F] = 1'b1; m[BIT_I] = 1'b1;
    m[BIT_M] = 1'b1; m[BIT_S] = 1'b1; m[BIT_U] = 1'b1;
    return m;
  endfunction

  typedef struct packed {
    logic store;
    logic clrD;
    logic clrC;
  } ext_strb_t;
endpackage

// File: rtl/isa_ext_ctrl.sv
module isa_ext_ctrl
  import isa_ext_pkg::*;
#(
  parameter int PC_LOW_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                writeAllow,
  input  logic                rawI,
  input  logic                rawE,
  input  logic                maskedD,
  input  logic                maskedF,
  input  logic                maskedC,
  input  logic [PC_LOW_W-1:0] nextPcLow,
  output ext_strb_t           strb
);
  logic writable;
  logic hasBase;
  logic pcMisaligned;

  always_comb begin
    writable     = wrEn && writeAllow;
    hasBase      = rawI || rawE;
    pcMisaligned = (nextPcLow != '0);
    strb.store   = writable && hasBase && !rawE;
    strb.clrD    = maskedD && !maskedF;
    strb.clrC    = maskedC && pcMisaligned;
  end

  // R2: locked register never stores
  p_locked_no_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    !writeAllow |-> !strb.store);
  // R3 / R4: an accepted write always names I and never E
  p_base_present_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.store |-> (rawI && !rawE));
endmodule

// File: rtl/isa_ext_dp.sv
module isa_ext_dp
  import isa_ext_pkg::*;
#(
  parameter logic [WCODE_W-1:0] NATIVE_CODE = 2'd1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [XLEN-1:0]    wrData,
  input  logic [LETTERS-1:0] supportMask,
  input  ext_strb_t          strb,
  input  logic               pcMisaligned,
  output logic [LETTERS-1:0] maskedLetters,
  output logic [XLEN-1:0]    regQ,
  output logic               pulseQ
);
  localparam logic [LETTERS-1:0] HANDLED = handledSet();

  logic [LETTERS-1:0] newLetters;
  logic [XLEN-1:0]    nextVal;

  assign maskedLetters = wrData[LETTERS-1:0] & supportMask & HANDLED;

  for (genvar b = 0; b < LETTERS; b++) begin : g_letter
    if (b == BIT_D) begin : g_d
      assign newLetters[b] = maskedLetters[b] && !strb.clrD;
    end else if (b == BIT_C) begin : g_c
      assign newLetters[b] = maskedLetters[b] && !strb.clrC;
    end else begin : g_plain
      assign newLetters[b] = maskedLetters[b];
    end
  end

  assign nextVal = {regQ[XLEN-1 -: WCODE_W], {PAD_W{1'b0}}, newLetters};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ   <= {NATIVE_CODE, {PAD_W{1'b0}}, supportMask};
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= strb.store && (nextVal != regQ);
      if (strb.store) regQ <= nextVal;
    end
  end

  // R2 / R3 / R4: no store strobe, no change
  p_hold_without_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !strb.store |=> $stable(regQ));
  // R8: width field survives any write data
  p_width_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && strb.store && (wrData[XLEN-1 -: WCODE_W] != regQ[XLEN-1 -: WCODE_W])
      |=> $stable(regQ[XLEN-1 -: WCODE_W]));
  // R6: stored D implies stored F after a write
  p_d_needs_f_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && strb.store |=> !(regQ[BIT_D] && !regQ[BIT_F]));
  // R7: misaligned fetch forbids C
  p_c_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && strb.store && pcMisaligned |=> !regQ[BIT_C]);
  // R9: a pulse means the value moved
  p_pulse_change_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && pulseQ |-> (regQ != $past(regQ)));
  // R5: unhandled letters never stored
  p_unhandled_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && strb.store |=> ((regQ[LETTERS-1:0] & ~HANDLED) == '0));
endmodule

// File: rtl/isa_ext_filter.sv
module isa_ext_filter
  import isa_ext_pkg::*;
#(
  parameter logic [WCODE_W-1:0] NATIVE_CODE = 2'd1,
  parameter int                 PC_LOW_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [XLEN-1:0]     wrData,
  input  logic [LETTERS-1:0]  supportMask,
  input  logic                writeAllow,
  input  logic [PC_LOW_W-1:0] nextPcLow,
  output logic [XLEN-1:0]     extReg,
  output logic                changePulse
);
  ext_strb_t          strb;
  logic [LETTERS-1:0] maskedLetters;

  isa_ext_ctrl #(.PC_LOW_W(PC_LOW_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .writeAllow (writeAllow),
    .rawI       (wrData[BIT_I]),
    .rawE       (wrData[BIT_E]),
    .maskedD    (maskedLetters[BIT_D]),
    .maskedF    (maskedLetters[BIT_F]),
    .maskedC    (maskedLetters[BIT_C]),
    .nextPcLow  (nextPcLow),
    .strb       (strb)
  );

  isa_ext_dp #(.NATIVE_CODE(NATIVE_CODE)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .wrData        (wrData),
    .supportMask   (supportMask),
    .strb          (strb),
    .pcMisaligned  (nextPcLow != '0),
    .maskedLetters (maskedLetters),
    .regQ          (extReg),
    .pulseQ        (changePulse)
  );
endmodule

// File: tb/isa_ext_filter_tb.sv
module isa_ext_filter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [25:0] supportMask = 26'h3FFFFFF;
  logic        writeAllow = 1'b1;
  logic [1:0]  nextPcLow = 2'd0;
  logic [31:0] extReg;
  logic        changePulse;

  int checks = 0;
  int failures = 0;
  logic [31:0] shadow;
  bit done = 0;

  localparam logic [25:0] HSET = 26'h0141000 | 26'h0000100 | 26'h000003D;

  always #5 clk = ~clk;

  isa_ext_filter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .supportMask(supportMask), .writeAllow(writeAllow),
    .nextPcLow(nextPcLow), .extReg(extReg), .changePulse(changePulse)
  );

  function automatic logic [31:0] model(logic [31:0] cur, logic [31:0] d,
      logic [25:0] m, logic allow, logic [1:0] pc);
    logic [25:0] l;
    if (!allow || !(d[8] || d[4]) || d[4]) return cur;
    l = d[25:0] & m & HSET;
    if (l[3] && !l[5]) l[3] = 1'b0;
    if (l[2] && pc != 2'd0) l[2] = 1'b0;
    return {cur[31:30], 4'b0, l};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(string req, logic [31:0] d, logic allow, logic [1:0] pc);
    logic [31:0] nx;
    @(negedge clk);
    wrEn = 1'b1; wrData = d; writeAllow = allow; nextPcLow = pc;
    nx = model(shadow, d, supportMask, allow, pc);
    #4;
    check({req, " R10 before edge"}, extReg, shadow);
    @(negedge clk);
    wrEn = 1'b0;
    check(req, extReg, nx);
    check({req, " R9 pulse"}, {31'b0, changePulse}, {31'b0, nx != shadow});
    shadow = nx;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    supportMask = 26'h3FFFFFF;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    shadow = {2'd1, 4'b0, 26'h3FFFFFF};
    check("R1 reset value", extReg, shadow);
    check("R1 pulse low", {31'b0, changePulse}, 32'd0);

    doWrite("R5 basic", 32'h0000_1105, 1'b1, 2'd0);
    doWrite("R2 locked", 32'h0000_0101, 1'b0, 2'd0);
    doWrite("R3 no base", 32'h0000_1001, 1'b1, 2'd0);
    doWrite("R4 E set", 32'h0000_0110, 1'b1, 2'd0);
    doWrite("R6 D without F", 32'h0000_0108, 1'b1, 2'd0);
    doWrite("R6 D with F", 32'h0000_0128, 1'b1, 2'd0);
    doWrite("R7 C aligned", 32'h0000_0104, 1'b1, 2'd0);
    doWrite("R7 C pc=2", 32'h0000_0104, 1'b1, 2'd2);
    doWrite("R7 C pc=1", 32'h0000_0105, 1'b1, 2'd1);
    doWrite("R8 width bits", 32'hFFFF_FFFF & ~32'h10, 1'b1, 2'd0);
    check("R8 width field", {30'b0, extReg[31:30]}, 32'd1);
    doWrite("R9 same value", 32'hFFFF_FFFF & ~32'h10, 1'b1, 2'd0);
    supportMask = 26'h0000_1FF;
    doWrite("R5 support mask", 32'h0014_112D, 1'b1, 2'd0);

    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 10) < 7) d[4] = 1'b0;
      if (($urandom % 10) < 8) d[8] = 1'b1;
      if (($urandom % 16) == 0) supportMask = $urandom;
      doWrite("R5/R6/R7/R9 random", d, ($urandom % 8) != 0, 2'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule